// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block drives a three-wire serial EEPROM organised as 128 bytes. It fills a 48-bit station address register automatically after every hard or soft reset. It starts by reading byte 0 of the EEPROM. If that byte holds the signature A5h, it reads bytes 1 to 6 and places them into the address register, lowest byte first, and then raises a loaded flag. If the signature is missing, the address register keeps its value so the host can program it, and the flag stays low.

Between auto-loads the host can read, write or erase any single byte through a small command port. A write or erase is only accepted by the EEPROM after a write-enable command. After a write or erase, the controller watches the EEPROM ready line and sets an error flag if the line does not go high within a bounded number of serial clock periods. A busy flag covers the auto-load and every host command. Commands that arrive while busy is high are dropped.

Top module: `eeprom_mac_loader`

## Requirements
- R1: Releasing `rst_n` or pulsing `soft_rst` starts the auto-load. `busy` is high from reset until the auto-load ends, and `mac_loaded` and `mac_addr` reset to 0 on `rst_n`.
- R2: The first auto-load frame reads EEPROM address 0. Only the value A5h there lets the sequence go on.
- R3: With a valid signature, EEPROM bytes 1..6 are read in order. Byte k+1 lands in `mac_addr[8k+7:8k]`, so byte 1 fills bits 7:0 and byte 6 fills bits 47:40.
- R4: `mac_loaded` is set once all six bytes are stored. A soft reset clears it.
- R5: If the signature is not A5h, `mac_addr` keeps its previous value and `mac_loaded` stays 0.
- R6: Host command `cmd_op`=00 reads the byte at `cmd_addr`. The frame is a start bit 1, opcode 10 and a 7-bit address, MSB first, followed by 8 data bits clocked in MSB first. The byte appears on `rd_data` when `busy` falls.
- R7: `cmd_op`=11 sends write-enable (opcode 00, address 1100000). `cmd_op`=01 writes `cmd_wdata` with opcode 01 and 8 data bits out. `cmd_op`=10 erases the byte to FFh with opcode 11.
- R8: `busy` is high while any operation runs. A `cmd_valid` seen while `busy` is high has no effect.
- R9: After a write or erase, `ee_cs` drops for one half serial period and then rises again, and `ee_do` is polled until it reads 1. If it does not read 1 within POLL_LIMIT serial half-periods, `timeout_err` is set. It clears when the next command is accepted.
- R10: `ee_sk` stays high for CLK_DIV system clocks in each period and is low while `ee_cs` is low. `ee_di` changes only when `ee_sk` falls or is low, and `ee_do` is sampled when `ee_sk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; restarts the auto-load |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 00 read, 01 write, 10 erase, 11 write-enable |
| cmd_addr | input | 7 | Byte address |
| cmd_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Result of the last host read |
| busy | output | 1 | Operation in progress |
| mac_addr | output | 48 | Station address register |
| mac_loaded | output | 1 | Auto-load completed |
| timeout_err | output | 1 | Ready poll timed out |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The hardest cases to reach are the ones that depend on what the EEPROM holds: a signature that fails, and a ready line that never rises. The bench contains a behavioural EEPROM that enforces write-enable and holds its ready line low for a while after each program. Host write commands change its contents so that byte 0 no longer holds the signature, and a soft reset then shows that the address register keeps its value. The same model can be told to stay busy forever, which forces the poll timeout. A command sent in the middle of a running read checks that it is dropped.

// File: rtl/eeprom_mac_loader.sv
module eeprom_mac_loader #(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [6:0]  cmd_addr,
  input  logic [7:0]  cmd_wdata,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic [47:0] mac_addr,
  output logic        mac_loaded,
  output logic        timeout_err,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);

  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PW   = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  localparam logic [1:0] S_IDLE = 2'd0, S_SHIFT = 2'd1, S_GAP = 2'd2, S_POLL = 2'd3;

  logic [1:0]      state;
  logic [DIVW-1:0] div_cnt;
  logic [PW-1:0]   poll_cnt;
  logic [17:0]     sr_out;
  logic [7:0]      sr_in;
  logic [4:0]      bit_idx, last;
  logic            is_rd, auto_run, cont, poll_pend;
  logic [2:0]      auto_step;
  logic            tick;

  function automatic logic [17:0] frame(input logic [1:0] wop, input logic [6:0] a,
                                        input logic [7:0] d);
    return {1'b1, wop, a, d};
  endfunction

  assign tick  = (div_cnt == DIVW'(CLK_DIV - 1));
  assign busy  = (state != S_IDLE);
  assign ee_di = ee_cs & sr_out[17];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_GAP; div_cnt <= '0; poll_cnt <= '0;
      sr_out <= frame(2'b10, 7'd0, 8'd0); sr_in <= '0;
      bit_idx <= '0; last <= 5'd17; is_rd <= 1'b1;
      auto_run <= 1'b1; auto_step <= '0; cont <= 1'b1; poll_pend <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0;
      mac_addr <= '0; mac_loaded <= 1'b0; timeout_err <= 1'b0; rd_data <= '0;
    end else if (soft_rst) begin
      state <= S_GAP; div_cnt <= '0;
      sr_out <= frame(2'b10, 7'd0, 8'd0);
      bit_idx <= '0; last <= 5'd17; is_rd <= 1'b1;
      auto_run <= 1'b1; auto_step <= '0; cont <= 1'b1; poll_pend <= 1'b0;
      ee_cs <= 1'b0; ee_sk <= 1'b0; mac_loaded <= 1'b0;
    end else begin
      div_cnt <= (state == S_IDLE || tick) ? '0 : div_cnt + 1'b1;
      case (state)
        S_IDLE: if (cmd_valid) begin
          timeout_err <= 1'b0; cont <= 1'b1; bit_idx <= '0; state <= S_GAP;
          case (cmd_op)
            2'b00: begin sr_out <= frame(2'b10, cmd_addr, 8'd0);
                         last <= 5'd17; is_rd <= 1'b1; poll_pend <= 1'b0; end
            2'b01: begin sr_out <= frame(2'b01, cmd_addr, cmd_wdata);
                         last <= 5'd17; is_rd <= 1'b0; poll_pend <= 1'b1; end
            2'b10: begin sr_out <= frame(2'b11, cmd_addr, 8'd0);
                         last <= 5'd9; is_rd <= 1'b0; poll_pend <= 1'b1; end
            default: begin sr_out <= frame(2'b00, 7'b1100000, 8'd0);
                         last <= 5'd9; is_rd <= 1'b0; poll_pend <= 1'b0; end
          endcase
        end
        S_GAP: if (tick) begin
          if (poll_pend) begin
            ee_cs <= 1'b1; poll_cnt <= '0; state <= S_POLL;
          end else if (cont) begin
            ee_cs <= 1'b1; state <= S_SHIFT;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
            if (is_rd && bit_idx >= 5'd10) sr_in <= {sr_in[6:0], ee_do};
          end else begin
            ee_sk  <= 1'b0;
            sr_out <= {sr_out[16:0], 1'b0};
            if (bit_idx == last) begin
              ee_cs <= 1'b0; bit_idx <= '0; state <= S_GAP;
              if (auto_run) begin
                if (auto_step == 3'd0 && sr_in != 8'hA5) begin
                  auto_run <= 1'b0; cont <= 1'b0;
                end else begin
                  for (int i = 0; i < 6; i++)
                    if (auto_step == 3'(i + 1)) mac_addr[i*8 +: 8] <= sr_in;
                  if (auto_step == 3'd6) begin
                    mac_loaded <= 1'b1; auto_run <= 1'b0; cont <= 1'b0;
                  end else begin
                    auto_step <= auto_step + 3'd1; cont <= 1'b1;
                    sr_out <= frame(2'b10, {4'd0, auto_step + 3'd1}, 8'd0);
                  end
                end
              end else begin
                cont <= 1'b0;
                if (is_rd) rd_data <= sr_in;
              end
            end else begin
              bit_idx <= bit_idx + 5'd1;
            end
          end
        end
        default: if (tick) begin
          if (ee_do) begin
            ee_cs <= 1'b0; poll_pend <= 1'b0; state <= S_GAP;
          end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
            timeout_err <= 1'b1; ee_cs <= 1'b0; poll_pend <= 1'b0; state <= S_GAP;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_SK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk); // R10
  AST_DI_HELD_WHILE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R10
  AST_MAC_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(mac_addr)); // R5
  AST_FRAME_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && $past(state == S_SHIFT)) |-> ($stable(is_rd) && $stable(last))); // R8
  AST_TIMEOUT_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(state == S_POLL)); // R9

endmodule

// File: tb/eeprom_mac_loader_tb.sv
module eeprom_mac_loader_tb;
  localparam int CLK_DIV = 2;
  localparam int POLL_LIMIT = 32;
  localparam int BUSY_T = 20;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] rd_data;
  logic busy, mac_loaded, timeout_err, ee_cs, ee_sk, ee_di, ee_do;
  logic [47:0] mac_addr;

  always #2 clk = ~clk;

  eeprom_mac_loader #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
    .busy(busy), .mac_addr(mac_addr), .mac_loaded(mac_loaded),
    .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  // behavioural EEPROM
  logic [7:0] mem [128];
  logic [17:0] sh = '0;
  int nb = 0, cyc = 0, busy_until = 0;
  logic wen = 1'b0, rd_ph = 1'b0, rd_bit = 1'b0, stuck = 1'b0;
  logic [7:0] rd_sh = '0;

  always @(posedge clk) cyc <= cyc + 1;
  assign ee_do = rd_ph ? rd_bit : ((cyc >= busy_until) && !stuck);

  always @(posedge ee_sk) if (ee_cs) begin
    sh = {sh[16:0], ee_di};
    nb = nb + 1;
    if (nb == 10 && sh[9] && sh[8:7] == 2'b10) begin
      rd_ph = 1'b1; rd_sh = mem[sh[6:0]];
    end
  end
  always @(negedge ee_sk) if (ee_cs && rd_ph) begin
    rd_bit = rd_sh[7]; rd_sh = {rd_sh[6:0], 1'b0};
  end
  always @(negedge ee_cs) begin
    if (nb == 10 && sh[9] && sh[8:7] == 2'b00 && sh[6:5] == 2'b11) wen = 1'b1;
    if (nb == 10 && sh[9] && sh[8:7] == 2'b11 && wen) begin
      mem[sh[6:0]] = 8'hFF; busy_until = cyc + BUSY_T;
    end
    if (nb == 18 && sh[17] && sh[16:15] == 2'b01 && wen) begin
      mem[sh[14:8]] = sh[7:0]; busy_until = cyc + BUSY_T;
    end
    nb = 0; rd_ph = 1'b0; sh = '0;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
    issue(op, a, d);
    wait_idle();
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [47:0] exp_mac, saved;
    int hi;
    for (int i = 0; i < 128; i++) mem[i] = pat(i);
    mem[0] = 8'hA5;
    exp_mac = '0;
    for (int i = 0; i < 6; i++) exp_mac[i*8 +: 8] = pat(i + 1);

    repeat (3) @(negedge clk);
    chk(ee_cs == 1'b0, "R10 cs low in reset", 64'(ee_cs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", 64'(busy), 1);
    chk(mac_loaded == 1'b0, "R1 loaded clear after reset", 64'(mac_loaded), 0);
    chk(mac_addr == 48'd0, "R1 mac zero after reset", mac_addr, 0);
    wait_idle();
    chk(mac_addr == exp_mac, "R2 R3 autoload mac", mac_addr, exp_mac);
    chk(mac_loaded == 1'b1, "R4 loaded set", 64'(mac_loaded), 1);

    // R10 serial clock high time
    issue(2'b00, 7'd3, 8'd0);
    while (!ee_sk) @(negedge clk);
    hi = 0;
    while (ee_sk) begin hi++; @(negedge clk); end
    chk(hi == CLK_DIV, "R10 sk high time", 64'(hi), 64'(CLK_DIV));
    wait_idle();

    // R6 full read sweep
    for (int a = 0; a < 128; a++) begin
      logic [7:0] e;
      e = (a == 0) ? 8'hA5 : pat(a);
      run(2'b00, 7'(a), 8'd0);
      chk(rd_data == e, "R6 read sweep", 64'(rd_data), 64'(e));
    end

    // R7 write without enable is refused by the EEPROM
    run(2'b01, 7'd20, 8'h3C);
    run(2'b00, 7'd20, 8'd0);
    chk(rd_data == pat(20), "R7 write before enable", 64'(rd_data), 64'(pat(20)));

    run(2'b11, 7'd0, 8'd0);
    for (int a = 20; a < 36; a++) begin
      logic [7:0] e;
      e = 8'((a * 11 + 3) & 255);
      run(2'b01, 7'(a), e);
      chk(timeout_err == 1'b0, "R9 no timeout on ready", 64'(timeout_err), 0);
      run(2'b00, 7'(a), 8'd0);
      chk(rd_data == e, "R7 write readback", 64'(rd_data), 64'(e));
    end
    run(2'b10, 7'd50, 8'd0);
    run(2'b00, 7'd50, 8'd0);
    chk(rd_data == 8'hFF, "R7 erase", 64'(rd_data), 64'hFF);

    // R8 command during busy dropped
    issue(2'b00, 7'd5, 8'd0);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during op", 64'(busy), 1);
    issue(2'b01, 7'd40, 8'h11);
    wait_idle();
    chk(rd_data == pat(5), "R8 running read intact", 64'(rd_data), 64'(pat(5)));
    run(2'b00, 7'd40, 8'd0);
    chk(rd_data == pat(40), "R8 busy command ignored", 64'(rd_data), 64'(pat(40)));

    // R9 timeout
    stuck = 1'b1;
    run(2'b01, 7'd60, 8'h77);
    chk(timeout_err == 1'b1, "R9 timeout set", 64'(timeout_err), 1);
    stuck = 1'b0;
    run(2'b00, 7'd61, 8'd0);
    chk(timeout_err == 1'b0, "R9 timeout cleared", 64'(timeout_err), 0);
    chk(rd_data == pat(61), "R9 read after timeout", 64'(rd_data), 64'(pat(61)));

    // R5 bad signature keeps mac
    run(2'b01, 7'd0, 8'h00);
    saved = mac_addr;
    pulse_soft();
    chk(mac_loaded == 1'b0, "R5 loaded clear on bad sig", 64'(mac_loaded), 0);
    chk(mac_addr == saved, "R5 mac unchanged", mac_addr, saved);

    // R4 soft reset with new content reloads
    run(2'b01, 7'd0, 8'hA5);
    for (int i = 1; i <= 6; i++) run(2'b01, 7'(i), 8'(8'hE0 + i));
    for (int i = 0; i < 6; i++) exp_mac[i*8 +: 8] = 8'(8'hE1 + i);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(mac_loaded == 1'b0 && busy == 1'b1, "R4 soft reset clears loaded", 64'({busy, mac_loaded}), 64'b10);
    wait_idle();
    chk(mac_addr == exp_mac, "R3 reload order", mac_addr, exp_mac);
    chk(mac_loaded == 1'b1, "R4 loaded after reload", 64'(mac_loaded), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule